// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Pair

This block holds two independent down-counters and one free-running up-counter, all advanced by a shared single-cycle `tick` strobe. Each down-counter decrements once per tick. On a tick where it already reads zero, it raises its overflow flag and reloads. In periodic mode it reloads from a programmable load register. In free-running mode it reloads from the all-ones maximum of the counter width. An overflow flag stays set until software writes the timer's clear register. Each flag drives its own interrupt output and also appears in a shared status word.

Software reaches the block through a simple word-addressed register port. A read request returns its data on `bus_rdata` one cycle later. Writes take effect at the clock edge that samples them. Word addresses are mapped as follows:

- Timer *i* occupies words `4*i` to `4*i+3`, which are load, current value, control and clear.
- Word 8 is the up-counter.
- Word 9 is the status word.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every timer value, load register, control register and overflow flag is zero, and so is the up-counter. `irq` is low and the status word (address 9) reads 0.
- R2: On a cycle with `tick` high, a timer whose value is nonzero decrements by exactly one. With `tick` low the value holds.
- R3: On a tick where a timer's value is zero and bit 6 of its control register is 1, the value becomes that timer's load register.
- R4: On a tick where a timer's value is zero and control bit 6 is 0, the value becomes all ones (0xFFFF for the default 16-bit width).
- R5: A tick at value zero sets that timer's overflow flag. The flag drives `irq[i]` and status bit 4+i (timer 0 at bit 4, timer 1 at bit 5), and it stays set across later ticks.
- R6: Any write to a timer's clear register (address 4*i+3) clears its overflow flag, whatever the data. If a zero-reaching tick lands in the same cycle as the clear write, the flag stays set.
- R7: Writes to the current-value register (address 4*i+1) are ignored. The value is unchanged.
- R8: The load register reads back the low counter-width bits of the last write, zero-extended. The control register reads back the low 8 bits of the last write. A read of a clear register returns 0.
- R9: The up-counter (address 8) increments by one on every tick and holds otherwise.
- R10: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable strobe for all counters |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 2 | Per-timer overflow interrupt |

## Verification
A miscounted or wrongly reloaded timer value shows at the value register on the first read after the faulty tick. Because the error also shifts every later zero crossing, the overflow interrupt then fires early or late. A flag that clears when it should not, or survives a clear, shows on `irq` one cycle after the edge concerned and on the next status read. The scoreboard compares each read against values derived from the tick count, so a one-off error in any counter is caught at the next read of that register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Word offsets inside one timer's four-word window
  localparam int OFS_LOAD  = 0;
  localparam int OFS_VALUE = 1;
  localparam int OFS_CTRL  = 2;
  localparam int OFS_CLEAR = 3;
  localparam int WIN_WORDS = 4;
  // Control register bit that selects periodic reload
  localparam int MODE_BIT  = 6;
  // First status bit used for timer overflow flags
  localparam int STAT_BASE = 4;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load_we,
  input  logic              ctrl_we,
  input  logic              clr_we,
  input  logic [CNT_W-1:0]  wdata_cnt,
  input  logic [CTRL_W-1:0] wdata_ctl,
  output logic [CNT_W-1:0]  value_q,
  output logic [CNT_W-1:0]  load_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              ovf_q
);
  logic at_zero;
  logic periodic;

  assign at_zero  = (value_q == '0);
  assign periodic = ctrl_q[MODE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      load_q  <= '0;
      ctrl_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (load_we) load_q <= wdata_cnt;
      if (ctrl_we) ctrl_q <= wdata_ctl;
      if (tick) begin
        if (at_zero) value_q <= periodic ? load_q : {CNT_W{1'b1}};
        else         value_q <= value_q - CNT_W'(1);
      end
      // a new zero crossing wins over a simultaneous clear
      if (tick && at_zero) ovf_q <= 1'b1;
      else if (clr_we)     ovf_q <= 1'b0;
    end
  end

  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (tick && value_q != '0) |=> (value_q == $past(value_q) - CNT_W'(1)));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(value_q));
  a_r3_periodic_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && value_q == '0 && ctrl_q[MODE_BIT]) |=> (value_q == $past(load_q)));
  a_r4_free_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && value_q == '0 && !ctrl_q[MODE_BIT]) |=> (value_q == {CNT_W{1'b1}}));
  a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
    (tick && value_q == '0) |=> ovf_q);
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !(tick && value_q == '0)) |=> !ovf_q);
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_we) |=> ovf_q);
endmodule

// File: rtl/tmr_upcount.sv
module tmr_upcount #(
  parameter int UP_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [UP_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= count_q + UP_W'(1);
  end

  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count_q == $past(count_q) + UP_W'(1)));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_q));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 16,
  parameter int CTRL_W  = 8,
  parameter int UP_W    = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = $clog2(NUM_TMR * WIN_WORDS + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_TMR-1:0] irq
);
  localparam int ADDR_UP   = NUM_TMR * WIN_WORDS;
  localparam int ADDR_STAT = ADDR_UP + 1;

  logic              wr_req;
  logic              rd_req;
  logic [CNT_W-1:0]  ch_value [NUM_TMR];
  logic [CNT_W-1:0]  ch_load  [NUM_TMR];
  logic [CTRL_W-1:0] ch_ctrl  [NUM_TMR];
  logic [NUM_TMR-1:0] ch_ovf;
  logic [UP_W-1:0]   up_count;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign wr_req       = bus_en && bus_we;
  assign rd_req       = bus_en && !bus_we;
  assign unused_wdata = ^bus_wdata;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * WIN_WORDS);
    tmr_channel #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .load_we   (wr_req && bus_addr == BASE + ADDR_W'(OFS_LOAD)),
      .ctrl_we   (wr_req && bus_addr == BASE + ADDR_W'(OFS_CTRL)),
      .clr_we    (wr_req && bus_addr == BASE + ADDR_W'(OFS_CLEAR)),
      .wdata_cnt (bus_wdata[CNT_W-1:0]),
      .wdata_ctl (bus_wdata[CTRL_W-1:0]),
      .value_q   (ch_value[i]),
      .load_q    (ch_load[i]),
      .ctrl_q    (ch_ctrl[i]),
      .ovf_q     (ch_ovf[i])
    );
    assign irq[i] = ch_ovf[i];
  end

  tmr_upcount #(.UP_W(UP_W)) u_up (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .count_q (up_count)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (bus_addr == ADDR_W'(i * WIN_WORDS + OFS_LOAD))  rd_mux = DATA_W'(ch_load[i]);
      if (bus_addr == ADDR_W'(i * WIN_WORDS + OFS_VALUE)) rd_mux = DATA_W'(ch_value[i]);
      if (bus_addr == ADDR_W'(i * WIN_WORDS + OFS_CTRL))  rd_mux = DATA_W'(ch_ctrl[i]);
    end
    if (bus_addr == ADDR_W'(ADDR_UP)) rd_mux = DATA_W'(up_count);
    if (bus_addr == ADDR_W'(ADDR_STAT)) begin
      for (int i = 0; i < NUM_TMR; i++) rd_mux[STAT_BASE + i] = ch_ovf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
  end

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(bus_rdata));
  a_r10_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_addr == ADDR_W'(OFS_CLEAR)) |=> (bus_rdata == '0));
  a_r5_irq_tracks_status: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_addr == ADDR_W'(ADDR_STAT)) |=>
      (bus_rdata[STAT_BASE +: NUM_TMR] == $past(irq)));
endmodule

// File: tb/tb_dual_reload_timer.sv
`timescale 1ns/1ps
module tb_dual_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_q = 1'b0;
  logic [31:0] e_val;
  string       e_tag;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dual_reload_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: a read issued at edge k is compared at the following negedge
  always @(posedge clk) rd_q <= bus_en && !bus_we;
  always @(negedge clk) begin
    if (rd_q) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10: unexpected read data %h, expected none", bus_rdata);
      end else begin
        e_val = exp_q.pop_front();
        e_tag = tag_q.pop_front();
        if (bus_rdata !== e_val) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", e_tag, bus_rdata, e_val);
        end
      end
    end
  end

  task automatic bus_op(input logic we, input logic [3:0] a, input logic [31:0] d,
                        input logic tk);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_op(1'b0, a, 32'h0, 1'b0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_op(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1; tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk_irq(input logic [1:0] exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk_irq(2'b00, "R1 irq");
    rd(4'd0, 32'h0, "R1 load0");
    rd(4'd1, 32'h0, "R1 value0");
    rd(4'd2, 32'h0, "R1 ctrl0");
    rd(4'd5, 32'h0, "R1 value1");
    rd(4'd8, 32'h0, "R1 upcount");
    rd(4'd9, 32'h0, "R1 status");

    // programming, read-back, ignored writes
    wr(4'd0, 32'h0000_0005);
    wr(4'd2, 32'h0000_0040);
    wr(4'd4, 32'hABCD_0003);
    wr(4'd6, 32'h0000_00BF);
    wr(4'd1, 32'h0000_1234);
    wr(4'd5, 32'h0000_0077);
    rd(4'd1, 32'h0, "R7 value0 write ignored");
    rd(4'd5, 32'h0, "R7 value1 write ignored");
    rd(4'd0, 32'h5, "R8 load0");
    rd(4'd4, 32'h3, "R8 load1 low bits");
    rd(4'd2, 32'h40, "R8 ctrl0");
    rd(4'd6, 32'hBF, "R8 ctrl1");
    rd(4'd3, 32'h0, "R8 clear0 reads zero");
    rd(4'd12, 32'h0, "R10 unmapped");

    // first tick: both at zero
    ticks(1);
    chk_irq(2'b11, "R5 irq both");
    rd(4'd1, 32'h5, "R3 periodic reload");
    rd(4'd5, 32'hFFFF, "R4 free reload");
    rd(4'd9, 32'h30, "R5 status");
    rd(4'd8, 32'h1, "R9 upcount");

    wr(4'd3, 32'hDEAD_BEEF);
    chk_irq(2'b10, "R6 irq after clear0");
    rd(4'd9, 32'h20, "R6 status after clear0");

    ticks(2);
    rd(4'd1, 32'h3, "R2 decrement");
    rd(4'd5, 32'hFFFD, "R2 decrement timer1");
    idle(5);
    rd(4'd1, 32'h3, "R2 hold without tick");
    rd(4'd8, 32'h3, "R9 upcount hold");

    ticks(3);
    rd(4'd1, 32'h0, "R2 reached zero");
    rd(4'd9, 32'h20, "R5 no flag before zero tick");
    ticks(1);
    rd(4'd1, 32'h5, "R3 second reload");
    rd(4'd9, 32'h30, "R5 flag on second crossing");
    rd(4'd8, 32'h7, "R9 upcount");
    wr(4'd7, 32'h0);
    rd(4'd9, 32'h10, "R6 clear timer1");

    wr(4'd3, 32'h0);
    rd(4'd9, 32'h0, "R6 clear timer0");
    ticks(5);
    rd(4'd1, 32'h0, "R2 zero again");
    bus_op(1'b1, 4'd3, 32'h0, 1'b1);
    chk_irq(2'b01, "R6 set wins over clear");
    rd(4'd9, 32'h10, "R6 status set wins");
    rd(4'd1, 32'h5, "R3 reload with clear");
    rd(4'd5, 32'hFFF3, "R2 timer1 running");
    rd(4'd8, 32'hD, "R9 upcount final");

    idle(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule